// File: doc/BRIEF.md
# DMA Channel Request Enable Gating

This block keeps one hardware-request enable bit for each of the 64 channels of a DMA engine and produces the registered vector of channel requests that the channel arbiter should consider. Peripheral request lines count only for channels whose enable is set. Software start requests and requests raised by channel linking are passed on regardless of the enable state.

Software reaches the enables over a simple memory-mapped bus. Two 32-bit windows hold all 64 bits. Two command registers set or clear a single channel's enable by channel number, or all channels at once, with no read-modify-write. When a channel completes its major loop and its descriptor asks for the request to be disabled afterwards, the block clears that channel's enable in hardware. A clear from hardware wins over any software update of the same bit in the same cycle.

Top module: `dma_req_gate`

## Requirements
- R1: After reset every enable bit is 0, both windows read 0 and `pend_o` is all zero.
- R2: A write to byte address 0x0C loads channels 31..0, with data bit k going to channel k. A write to 0x08 loads channels 63..32, with data bit k going to channel 32+k. Reads of those addresses return the same mapping and change nothing. Any other address reads 0, and a write to it leaves every enable unchanged.
- R3: A write to the set command at 0x18 with data bit 6 clear sets the enable of the channel numbered by data bits 5..0 and leaves all other enables unchanged.
- R4: A write to the clear command at 0x1C with data bit 6 clear clears the enable of the channel numbered by data bits 5..0 and leaves all other enables unchanged.
- R5: A write to either command register with data bit 6 set applies the set or the clear to all 64 channels. Bits 5..0 are then ignored.
- R6: Every register write changes the enables at the first rising clock edge that samples `we_i` high, and not earlier.
- R7: A peripheral request on `hw_req_i[c]` reaches `pend_o[c]` only while channel c's enable is 1.
- R8: `sw_start_i[c]` or `link_req_i[c]` drives `pend_o[c]` high whatever channel c's enable is.
- R9: When `done_i[c]` and `dis_req_i[c]` are both high at a clock edge, channel c's enable is 0 after that edge. `done_i[c]` alone leaves the enable unchanged.
- R10: A hardware clear of channel c in the same cycle as a software set or window write of channel c leaves the enable at 0.
- R11: `pend_o` equals `(hw_req_i & enables) | sw_start_i | link_req_i` as sampled at the previous clock edge, which is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Bus write strobe |
| addr_i | input | 8 | Bus byte address |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Bus read data for `addr_i`, combinational |
| hw_req_i | input | 64 | Peripheral request per channel |
| sw_start_i | input | 64 | Software start request per channel |
| link_req_i | input | 64 | Linked-channel request per channel |
| done_i | input | 64 | Major loop completed, per channel |
| dis_req_i | input | 64 | Descriptor flag asking to disable the request at loop end, per channel |
| pend_o | output | 64 | Qualified pending requests, registered |

## Verification
The bench sets every channel one at a time and then clears every channel one at a time. After each step it reads back both windows. A decoder that is off by one, or a mistake that swaps the two windows, shows up as a neighbouring bit or the wrong half. The all-channels bit is written together with a non-zero channel field, so a decoder that ignores bit 6 changes only a single channel. Hardware requests are walked through every channel against a mixed enable pattern. Software start and link requests are driven with every enable clear, so any gating applied to them drops the request. The bench lines up a loop-done clear in the same cycle as a command set and as a window write, so a design with the wrong priority leaves the bit at 1. It also samples `pend_o` one cycle after a set command, where a design that forwards the write early shows the request a cycle too soon.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  localparam int unsigned NUM_CH = 64;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] WIN_TOP_ADDR = 8'h08; // window of the highest channels
  localparam logic [ADDR_W-1:0] SET_ADDR     = 8'h18;
  localparam logic [ADDR_W-1:0] CLR_ADDR     = 8'h1C;

  // window w holds channels w*DATA_W +: DATA_W; highest window sits lowest in the map
  function automatic logic [ADDR_W-1:0] win_addr(int unsigned w, int unsigned nwin);
    return WIN_TOP_ADDR + ADDR_W'((nwin - 1 - w) * 4);
  endfunction
endpackage

// File: rtl/dma_en_decode.sv
module dma_en_decode
  import dma_req_pkg::*;
#(
  parameter int unsigned NCH = NUM_CH,
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned AW  = ADDR_W,
  localparam int unsigned CHW  = $clog2(NCH),
  localparam int unsigned NWIN = NCH / DW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [CHW:0]    cmd_i,
  input  logic [NCH-1:0]  en_i,
  output logic [NWIN-1:0] win_we_o,
  output logic [NCH-1:0]  set_mask_o,
  output logic [NCH-1:0]  clr_mask_o,
  output logic [DW-1:0]   rdata_o
);
  logic set_hit, clr_hit, all_sel;
  logic [CHW-1:0] ch_sel;
  logic [NWIN-1:0] win_hit;

  assign set_hit = we_i && (addr_i == SET_ADDR);
  assign clr_hit = we_i && (addr_i == CLR_ADDR);
  assign all_sel = cmd_i[CHW];
  assign ch_sel  = cmd_i[CHW-1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel;
    assign sel           = all_sel || (ch_sel == CHW'(c));
    assign set_mask_o[c] = set_hit && sel;
    assign clr_mask_o[c] = clr_hit && sel;
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign win_hit[w]  = (addr_i == win_addr(w, NWIN));
    assign win_we_o[w] = we_i && win_hit[w];
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NWIN; w++)
      if (win_hit[w]) rdata_o = en_i[w*DW +: DW];
  end

  a_r3_single_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_hit && !all_sel) |-> ($countones(set_mask_o) == 1));
  a_r5_all_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_hit && all_sel) |-> (&set_mask_o));
  a_r4_set_clr_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_mask_o & clr_mask_o) == '0);
endmodule

// File: rtl/dma_en_store.sv
module dma_en_store
  import dma_req_pkg::*;
#(
  parameter int unsigned NCH = NUM_CH,
  parameter int unsigned DW  = DATA_W,
  localparam int unsigned NWIN = NCH / DW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NWIN-1:0] win_we_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [NCH-1:0]  set_mask_i,
  input  logic [NCH-1:0]  clr_mask_i,
  input  logic [NCH-1:0]  hw_clr_i,
  output logic [NCH-1:0]  en_o
);
  logic [NCH-1:0] en_q, win_mask;

  for (genvar c = 0; c < NCH; c++) begin : g_bit
    localparam int unsigned W = c / DW;
    localparam int unsigned B = c % DW;
    assign win_mask[c] = win_we_i[W];
    // hardware clear > software clear > set > window load
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            en_q[c] <= 1'b0;
      else if (hw_clr_i[c])   en_q[c] <= 1'b0;
      else if (clr_mask_i[c]) en_q[c] <= 1'b0;
      else if (set_mask_i[c]) en_q[c] <= 1'b1;
      else if (win_mask[c])   en_q[c] <= wdata_i[B];
    end
  end

  assign en_o = en_q;

  a_r9_auto_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hw_clr_i) |=> ((en_o & $past(hw_clr_i)) == '0));
  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_mask_i) |=> ((en_o & $past(clr_mask_i)) == '0));
  a_r3_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_mask_i) |=> ((en_o & $past(set_mask_i & ~hw_clr_i)) == $past(set_mask_i & ~hw_clr_i)));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_o ^ $past(en_o)) & ~$past(hw_clr_i | clr_mask_i | set_mask_i | win_mask)) == '0);
endmodule

// File: rtl/dma_req_qual.sv
module dma_req_qual
  import dma_req_pkg::*;
#(
  parameter int unsigned NCH = NUM_CH
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] hw_req_i,
  input  logic [NCH-1:0] sw_start_i,
  input  logic [NCH-1:0] link_req_i,
  input  logic [NCH-1:0] done_i,
  input  logic [NCH-1:0] dis_req_i,
  input  logic [NCH-1:0] en_i,
  output logic [NCH-1:0] hw_clr_o,
  output logic [NCH-1:0] pend_o
);
  logic [NCH-1:0] pend_q;

  assign hw_clr_o = done_i & dis_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (hw_req_i & en_i) | sw_start_i | link_req_i;
  end

  assign pend_o = pend_q;

  a_r7_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o & ~$past(sw_start_i | link_req_i) & ~$past(hw_req_i)) == '0);
  a_r7_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o & ~$past(sw_start_i | link_req_i) & ~$past(en_i)) == '0);
  a_r8_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o & $past(sw_start_i | link_req_i)) == $past(sw_start_i | link_req_i));
endmodule

// File: rtl/dma_req_gate.sv
module dma_req_gate
  import dma_req_pkg::*;
#(
  parameter int unsigned NCH = NUM_CH,
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned AW  = ADDR_W,
  localparam int unsigned CHW  = $clog2(NCH),
  localparam int unsigned NWIN = NCH / DW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  input  logic [NCH-1:0] hw_req_i,
  input  logic [NCH-1:0] sw_start_i,
  input  logic [NCH-1:0] link_req_i,
  input  logic [NCH-1:0] done_i,
  input  logic [NCH-1:0] dis_req_i,
  output logic [NCH-1:0] pend_o
);
  logic [NWIN-1:0] win_we;
  logic [NCH-1:0]  set_mask, clr_mask, hw_clr, en;

  dma_en_decode #(.NCH(NCH), .DW(DW), .AW(AW)) u_decode (
    .clk_i, .rst_ni, .we_i, .addr_i,
    .cmd_i      (wdata_i[CHW:0]),
    .en_i       (en),
    .win_we_o   (win_we),
    .set_mask_o (set_mask),
    .clr_mask_o (clr_mask),
    .rdata_o
  );

  dma_en_store #(.NCH(NCH), .DW(DW)) u_store (
    .clk_i, .rst_ni,
    .win_we_i   (win_we),
    .wdata_i,
    .set_mask_i (set_mask),
    .clr_mask_i (clr_mask),
    .hw_clr_i   (hw_clr),
    .en_o       (en)
  );

  dma_req_qual #(.NCH(NCH)) u_qual (
    .clk_i, .rst_ni, .hw_req_i, .sw_start_i, .link_req_i, .done_i, .dis_req_i,
    .en_i     (en),
    .hw_clr_o (hw_clr),
    .pend_o
  );
endmodule

// File: tb/dma_req_gate_test.sv
`timescale 1ns/1ps
module dma_req_gate_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [63:0] hw_req_i = '0, sw_start_i = '0, link_req_i = '0, done_i = '0, dis_req_i = '0;
  logic [63:0] pend_o;

  int errors = 0;
  int checks = 0;
  logic [63:0] en_m = '0;

  localparam logic [7:0] A_HI = 8'h08, A_LO = 8'h0C, A_SET = 8'h18, A_CLR = 8'h1C;

  always #2.5 clk_i = ~clk_i;

  dma_req_gate uut (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0; addr_i = 8'h00; wdata_i = '0;
  endtask

  task automatic rd_all(output logic [63:0] v);
    addr_i = A_HI; #1; v[63:32] = rdata_o;
    addr_i = A_LO; #1; v[31:0]  = rdata_o;
    addr_i = 8'h00;
  endtask

  task automatic req(string tag, logic [63:0] hw, logic [63:0] sw, logic [63:0] ln);
    @(negedge clk_i);
    hw_req_i = hw; sw_start_i = sw; link_req_i = ln;
    @(negedge clk_i);
    chk(tag, pend_o, (hw & en_m) | sw | ln);
    hw_req_i = '0; sw_start_i = '0; link_req_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd_all(v); chk("R1 reset enables", v, '0);
    chk("R1 reset pend", pend_o, '0);
    addr_i = 8'h10; #1; chk("R2 unmapped read", {32'h0, rdata_o}, '0);

    // R3 sweep: set each channel
    for (int c = 0; c < 64; c++) begin
      wr(A_SET, 32'(c));
      en_m[c] = 1'b1;
      rd_all(v); chk($sformatf("R3 set ch%0d", c), v, en_m);
    end
    // R4 sweep: clear each channel, high to low
    for (int c = 63; c >= 0; c--) begin
      wr(A_CLR, 32'(c));
      en_m[c] = 1'b0;
      rd_all(v); chk($sformatf("R4 clear ch%0d", c), v, en_m);
    end

    // R5 all-channel bit with non-zero channel field
    wr(A_SET, 32'h0000_0045); en_m = '1;
    rd_all(v); chk("R5 set all", v, en_m);
    wr(A_CLR, 32'h0000_007F); en_m = '0;
    rd_all(v); chk("R5 clear all", v, en_m);

    // R2 window mapping
    wr(A_HI, 32'h8000_0001); en_m[63:32] = 32'h8000_0001;
    rd_all(v); chk("R2 high window", v, en_m);
    wr(A_LO, 32'h0000_0005); en_m[31:0] = 32'h0000_0005;
    rd_all(v); chk("R2 low window", v, en_m);
    req("R2 ch63 via pend", 64'h8000_0000_0000_0000, '0, '0);
    req("R2 ch32 via pend", 64'h0000_0001_0000_0000, '0, '0);
    wr(8'h10, 32'hFFFF_FFFF);
    rd_all(v); chk("R2 unmapped write ignored", v, en_m);
    rd_all(v); chk("R2 read no side effect", v, en_m);

    // R6/R11 timing: set ch7 while its request is held
    @(negedge clk_i);
    hw_req_i = 64'h80; we_i = 1'b1; addr_i = A_SET; wdata_i = 32'd7;
    @(negedge clk_i);
    we_i = 1'b0; addr_i = 8'h00; wdata_i = '0;
    chk("R6 old enable used at write edge", pend_o & 64'h80, '0);
    en_m[7] = 1'b1;
    @(negedge clk_i);
    chk("R11 pend one cycle after enable", pend_o & 64'h80, 64'h80);
    hw_req_i = '0;
    @(negedge clk_i);

    // R7 walking request over mixed enables
    wr(A_HI, 32'hA5C3_0F69); en_m[63:32] = 32'hA5C3_0F69;
    wr(A_LO, 32'h3C96_E1B4); en_m[31:0]  = 32'h3C96_E1B4;
    for (int c = 0; c < 64; c++)
      req($sformatf("R7 hw ch%0d", c), 64'd1 << c, '0, '0);
    req("R7 all hw", '1, '0, '0);
    req("R11 mixed or", 64'hF0F0_0000_FFFF_0000, 64'h1, 64'h8000_0000_0000_0000);

    // R8 bypass with enables clear
    wr(A_CLR, 32'h40); en_m = '0;
    req("R8 sw start bypass", '0, 64'hDEAD_BEEF_0123_4567, '0);
    req("R8 link bypass", '0, '0, 64'h0F00_00F0_8000_0001);
    req("R7 hw blocked when disabled", '1, '0, '0);

    // R9 auto clear
    wr(A_SET, 32'h40); en_m = '1;
    @(negedge clk_i);
    done_i = (64'd1 << 5) | (64'd1 << 40); dis_req_i = (64'd1 << 5) | (64'd1 << 9);
    @(negedge clk_i);
    done_i = '0; dis_req_i = '0;
    en_m[5] = 1'b0;
    rd_all(v); chk("R9 auto clear only done+flag", v, en_m);

    // R10 collision with set command
    wr(A_CLR, 32'd12); en_m[12] = 1'b0;
    @(negedge clk_i);
    we_i = 1'b1; addr_i = A_SET; wdata_i = 32'd12;
    done_i = 64'd1 << 12; dis_req_i = 64'd1 << 12;
    @(negedge clk_i);
    we_i = 1'b0; addr_i = 8'h00; wdata_i = '0; done_i = '0; dis_req_i = '0;
    rd_all(v); chk("R10 clear beats set", v, en_m);
    // R10 collision with window write
    @(negedge clk_i);
    we_i = 1'b1; addr_i = A_HI; wdata_i = 32'h0000_0300;
    done_i = 64'd1 << 40; dis_req_i = 64'd1 << 40;
    @(negedge clk_i);
    we_i = 1'b0; addr_i = 8'h00; wdata_i = '0; done_i = '0; dis_req_i = '0;
    en_m[63:32] = 32'h0000_0200;
    rd_all(v); chk("R10 clear beats window write", v, en_m);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule